// File: doc/BRIEF.md
# 8-bit Timer Channel with Compare Outputs and Switchable Capture

This block is one 8-bit timer channel. An up-counter advances on a count-enable strobe. Two constant registers, A and B, are compared against it. Register A always works as a compare register and drives output pin A. Register B has two roles, chosen by one enable bit in the control/status register:
- When capture is off, it is a second compare register that drives output pin B.
- When capture is on, it is a capture register. It takes the counter value on a chosen edge of an external input, which is synchronized first.

Three sticky flags record compare matches and counter overflow. Software clears a flag in two steps: it reads the flag while the flag is set, then writes zero to that flag's bit. A plain zero write does not clear it, and a one write is never taken as a clear. All state can be reached through a small register bus with single-cycle strobes and combinational read data.

Top module: `tmr8_ccap`

## Requirements
- R1: Register addresses are 0 = control/status, 1 = counter, 2 = constant A, 3 = constant B. Each is written with `bus_wr` and read on `bus_rdata`. The counter adds one at each clock edge where `cnt_en` is high. A bus write to the counter in the same cycle takes priority over counting. With no strobe and no write, the counter holds its value.
- R2: The control/status bits are, from bit 7 to bit 0: flag B, flag A, overflow flag, capture enable, select B[1:0], select A[1:0]. Bits 4..0 read back what was written. The three flag bits never become 1 through a bus write.
- R3: The overflow flag (bit 5) sets after a count step taken while the counter is 0xFF. The counter becomes 0x00 in that step.
- R4: A count step taken while the counter equals constant A sets flag A (bit 6). At the same edge it applies select A to `pin_a`: 00 keeps the pin, 01 drives it low, 10 drives it high, 11 inverts it.
- R5: With capture enable at 0, a count step taken while the counter equals constant B sets flag B (bit 7). It also applies select B to `pin_b` with the same four codes.
- R6: A match is evaluated only in a count-step cycle. A counter that sits at a matching value without stepping causes no further pin action.
- R7: With capture enable at 1, `cap_in` passes through two flip-flops and then edge detection. Select B picks the edge: 00 rising, 01 falling, 1x both. On a selected edge, constant B loads the counter value from the detection cycle and flag B sets. A non-selected edge leaves both unchanged.
- R8: While capture enable is 1, `pin_b` does not change, and compare B sets no flag.
- R9: A flag clears only on a control write with a 0 in its bit, after a control read that saw it at 1. A zero write with no such earlier read has no effect. Writing 1 to a flag bit has no effect.
- R10: If hardware sets a flag in the same cycle as a qualifying clear write, the flag stays 1.
- R11: After reset, all four registers read 0x00 and both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-enable strobe, one step per high cycle |
| cap_in | input | 1 | External capture input (asynchronous) |
| bus_rd | input | 1 | Read strobe, used to arm flag clearing |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_a | output | 1 | Compare output A |
| pin_b | output | 1 | Compare output B |

## Verification
Two events can land on the same flag in the same cycle: a hardware set and a software clear. The bench provokes this on flag A. It first arms the flag with a control read. It then raises `cnt_en` while the counter equals constant A, and in that same cycle writes zero to the flag bit. The flag must still read 1 afterwards, and a normal read-and-zero-write pair must then clear it. A second overlap comes from the role switch: with capture enabled, the bench steps the counter through the value held in register B and checks that `pin_b` and flag B stay untouched.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CONA = 2'd2;
  localparam logic [ADDR_W-1:0] A_CONB = 2'd3;

  localparam int NFLAGS   = 3;
  localparam int FLAG_LSB = 5;  // ovf=5, A=6, B=7
  localparam int CAPEN_B  = 4;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } pin_act_e;

  function automatic logic apply_act(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    if (sel[1])      return rise | fall;
    else if (sel[0]) return fall;
    else             return rise;
  endfunction

endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~last;
  assign fall_o = ~chain[STAGES-1] & last;
endmodule

// File: rtl/tmr8_pin_ctl.sv
module tmr8_pin_ctl
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic [1:0] act_i,
  output logic       pin_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_o <= 1'b0;
    else if (fire_i) pin_o <= apply_act(act_i, pin_o);
  end
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic armed;
  logic clr_now;

  assign clr_now = wr_i & ~wr_bit_i & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      flag_o <= set_i | (flag_o & ~clr_now);
      if (clr_now)              armed <= 1'b0;
      else if (rd_i && flag_o)  armed <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr8_ccap.sv
module tmr8_ccap
  import tmr8_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cap_in,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          pin_a,
  output logic          pin_b
);
  localparam logic [W-1:0] CNT_TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt, reg_a, reg_b;
  logic         cap_en;
  logic [1:0]   sel_a, sel_b;
  logic [NFLAGS-1:0] flg, flg_set;

  // named internal events
  logic wr_ctrl, wr_cnt, wr_a, wr_b, rd_ctrl;
  logic step, evt_ovf, evt_cmp_a, evt_cmp_b, evt_cap;
  logic cap_rise, cap_fall;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt  = bus_wr && (bus_addr == A_CNT);
  assign wr_a    = bus_wr && (bus_addr == A_CONA);
  assign wr_b    = bus_wr && (bus_addr == A_CONB);
  assign rd_ctrl = bus_rd && (bus_addr == A_CTRL);

  assign step      = cnt_en && !wr_cnt;
  assign evt_ovf   = step && (cnt == CNT_TOP);
  assign evt_cmp_a = step && (cnt == reg_a);
  assign evt_cmp_b = step && !cap_en && (cnt == reg_b);
  assign evt_cap   = cap_en && edge_hit(sel_b, cap_rise, cap_fall);

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise_o(cap_rise), .fall_o(cap_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_cnt) cnt <= bus_wdata;
    else if (step)   cnt <= cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    reg_a <= '0;
    else if (wr_a) reg_a <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reg_b <= '0;
    else if (evt_cap) reg_b <= cnt;
    else if (wr_b)    reg_b <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en <= 1'b0;
      sel_b  <= 2'b00;
      sel_a  <= 2'b00;
    end else if (wr_ctrl) begin
      cap_en <= bus_wdata[CAPEN_B];
      sel_b  <= bus_wdata[3:2];
      sel_a  <= bus_wdata[1:0];
    end
  end

  assign flg_set = {evt_cmp_b | evt_cap, evt_cmp_a, evt_ovf};

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    tmr8_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(flg_set[i]), .rd_i(rd_ctrl),
      .wr_i(wr_ctrl), .wr_bit_i(bus_wdata[FLAG_LSB+i]), .flag_o(flg[i])
    );
  end

  tmr8_pin_ctl u_pin_a (
    .clk(clk), .rst_n(rst_n), .fire_i(evt_cmp_a), .act_i(sel_a), .pin_o(pin_a)
  );
  tmr8_pin_ctl u_pin_b (
    .clk(clk), .rst_n(rst_n), .fire_i(evt_cmp_b), .act_i(sel_b), .pin_o(pin_b)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[7:0] = {flg[2], flg[1], flg[0], cap_en, sel_b, sel_a};
      A_CNT:  bus_rdata = cnt;
      A_CONA: bus_rdata = reg_a;
      default: bus_rdata = reg_b;
    endcase
  end
endmodule

// File: rtl/tmr8_ccap_chk.sv
module tmr8_ccap_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reg_b,
  input logic         cap_en,
  input logic         pin_b,
  input logic [2:0]   flg,
  input logic         step,
  input logic         evt_ovf,
  input logic         evt_cmp_a,
  input logic         evt_cap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) + ONE);

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !(bus_wr && bus_addr == 2'd1)) |=> $stable(cnt));

  assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> flg[0]);

  assert_capture_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap |=> (reg_b == $past(cnt)) && flg[2]);

  assert_pinb_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> $stable(pin_b));

  assert_flag_a_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[1] && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[6])) |=> flg[1]);

  assert_flag_b_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[2] && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[7])) |=> flg[2]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmp_a |=> flg[1]);
endmodule

bind tmr8_ccap tmr8_ccap_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt), .reg_b(reg_b), .cap_en(cap_en), .pin_b(pin_b),
  .flg(flg), .step(step), .evt_ovf(evt_ovf), .evt_cmp_a(evt_cmp_a), .evt_cap(evt_cap)
);

// File: tb/tb_tmr8_ccap.sv
`timescale 1ns/1ps
module tb_tmr8_ccap;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b0, cap_in = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic pin_a, pin_b;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  tmr8_ccap dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_a(pin_a), .pin_b(pin_b)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic step(input int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R11 register reset", d, 8'h00);
    end
    check("R11 pin_a reset", {7'b0, pin_a}, 8'h00);
    check("R11 pin_b reset", {7'b0, pin_b}, 8'h00);
    wr(2'd0, 8'hFB); rd(2'd0, d);
    check("R2 ctrl readback, flag ones ignored", d, 8'h1B);
    wr(2'd0, 8'hE0);
  endtask

  task automatic t_counter();
    logic [7:0] d;
    wr(2'd1, 8'h10); step(3); rd(2'd1, d);
    check("R1 counter three steps", d, 8'h13);
    idle(4); rd(2'd1, d);
    check("R1 counter holds", d, 8'h13);
    wr(2'd2, 8'h5A); rd(2'd2, d); check("R1 constant A rw", d, 8'h5A);
    wr(2'd3, 8'hA5); rd(2'd3, d); check("R1 constant B rw", d, 8'hA5);
  endtask

  task automatic t_ovf();
    logic [7:0] d;
    wr(2'd1, 8'hFE); step(1); rd(2'd0, d);
    check("R3 no ovf at FE->FF", {7'b0, d[5]}, 8'h00);
    step(1); rd(2'd1, d); check("R3 wrap to 00", d, 8'h00);
    rd(2'd0, d); check("R3 ovf set", {7'b0, d[5]}, 8'h01);
    wr(2'd0, 8'h00); rd(2'd0, d);
    check("R9 read then zero write clears", {7'b0, d[5]}, 8'h00);
    wr(2'd1, 8'hFF); step(1);
    wr(2'd0, 8'h00); rd(2'd0, d);
    check("R9 zero write without read ignored", {7'b0, d[5]}, 8'h01);
    wr(2'd0, 8'h20); rd(2'd0, d);
    check("R9 one write ignored", {7'b0, d[5]}, 8'h01);
    wr(2'd0, 8'h00); rd(2'd0, d);
    check("R9 clear after read", {7'b0, d[5]}, 8'h00);
  endtask

  task automatic t_cmp_a();
    logic [7:0] d;
    wr(2'd2, 8'h40);
    wr(2'd0, 8'hE2); wr(2'd1, 8'h40); step(1);
    check("R4 code 10 drives high", {7'b0, pin_a}, 8'h01);
    rd(2'd0, d); check("R4 flag A set", {7'b0, d[6]}, 8'h01);
    wr(2'd0, 8'hE1); wr(2'd1, 8'h40); step(1);
    check("R4 code 01 drives low", {7'b0, pin_a}, 8'h00);
    wr(2'd0, 8'hE3); wr(2'd1, 8'h40); step(1);
    check("R4 code 11 toggles up", {7'b0, pin_a}, 8'h01);
    wr(2'd1, 8'h40); step(1);
    check("R4 code 11 toggles down", {7'b0, pin_a}, 8'h00);
    wr(2'd1, 8'h40); idle(5);
    check("R6 stalled at match, no action", {7'b0, pin_a}, 8'h00);
    step(1); idle(5);
    check("R6 one toggle per step", {7'b0, pin_a}, 8'h01);
    wr(2'd0, 8'hE0); wr(2'd1, 8'h40); step(1);
    check("R4 code 00 keeps pin", {7'b0, pin_a}, 8'h01);
    rd(2'd0, d); wr(2'd0, 8'hA0); rd(2'd0, d);
    check("R9 flag A cleared", {7'b0, d[6]}, 8'h00);
  endtask

  task automatic t_cmp_b();
    logic [7:0] d;
    wr(2'd0, 8'hE8); wr(2'd3, 8'h80); wr(2'd1, 8'h80); step(1);
    check("R5 compare B drives high", {7'b0, pin_b}, 8'h01);
    rd(2'd0, d); check("R5 flag B set", {7'b0, d[7]}, 8'h01);
    wr(2'd0, 8'h68); rd(2'd0, d);
    check("R9 flag B cleared", {7'b0, d[7]}, 8'h00);
  endtask

  task automatic clr_b(input logic [7:0] mode);
    logic [7:0] d;
    rd(2'd0, d); wr(2'd0, 8'h60 | mode);
  endtask

  task automatic t_capture();
    logic [7:0] d;
    wr(2'd0, 8'hF0); wr(2'd1, 8'h55);
    @(negedge clk); cap_in = 1'b1; idle(4);
    rd(2'd3, d); check("R7 rising capture", d, 8'h55);
    rd(2'd0, d); check("R7 flag B on capture", {7'b0, d[7]}, 8'h01);
    check("R8 pin_b held in capture", {7'b0, pin_b}, 8'h01);
    clr_b(8'h14); wr(2'd1, 8'h66);
    @(negedge clk); cap_in = 1'b0; idle(4);
    rd(2'd3, d); check("R7 falling capture", d, 8'h66);
    clr_b(8'h14); wr(2'd1, 8'h77);
    @(negedge clk); cap_in = 1'b1; idle(4);
    rd(2'd3, d); check("R7 rising ignored in falling mode", d, 8'h66);
    rd(2'd0, d); check("R7 no flag on ignored edge", {7'b0, d[7]}, 8'h00);
    wr(2'd3, 8'h30); wr(2'd1, 8'h30); step(1);
    check("R8 no pin action in capture mode", {7'b0, pin_b}, 8'h01);
    rd(2'd0, d); check("R8 no compare flag in capture mode", {7'b0, d[7]}, 8'h00);
    wr(2'd0, 8'hF8); wr(2'd1, 8'h88);
    @(negedge clk); cap_in = 1'b0; idle(4);
    rd(2'd3, d); check("R7 both-edge falling", d, 8'h88);
    clr_b(8'h18); wr(2'd1, 8'h99);
    @(negedge clk); cap_in = 1'b1; idle(4);
    rd(2'd3, d); check("R7 both-edge rising", d, 8'h99);
    clr_b(8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    wr(2'd0, 8'hE0); wr(2'd2, 8'h40); wr(2'd1, 8'h40); step(1);
    rd(2'd0, d); check("R4 flag A set again", {7'b0, d[6]}, 8'h01);
    wr(2'd1, 8'h40);
    @(negedge clk); cnt_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h00;
    @(negedge clk); cnt_en = 1'b0; bus_wr = 1'b0;
    rd(2'd0, d); check("R10 set wins over clear", {7'b0, d[6]}, 8'h01);
    wr(2'd0, 8'h00); rd(2'd0, d);
    check("R10 later clear works", {7'b0, d[6]}, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_counter();
    t_ovf();
    t_cmp_a();
    t_cmp_b();
    t_capture();
    t_set_wins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule